// File: doc/BRIEF.md
# I2C Bus Busy Tracker

This block watches the already synchronized SDA and SCL lines of a multi-master I2C bus. It keeps a busy flag that tells a local transfer engine whether another master holds the bus. It also keeps a sticky bus-free flag that records a STOP condition, and it gives a single-cycle activity pulse whenever one of the flags is raised. The tracker keeps running whenever it is enabled, whether or not the local controller is idle.

On the first enabled clock edge, whether that follows reset or a re-enable, the busy flag is seeded from the line levels alone. Only SDA low with SCL high seeds it as busy. This seed can be wrong when another master is part way through a transfer. The flag becomes trustworthy once activity has been seen on the bus: a START, a STOP, or SDA held low while SCL is high. Software clears the bus-free flag by writing one to it.

Top module: `i2c_busy_tracker`

## Requirements
- R1: While rst_ni is low, busy_o, free_o and evt_o are all 0.
- R2: On the first clock edge with en_i high after reset or after en_i was low, busy_o takes the value 1 if sda_i=0 and scl_i=1 at that edge, and 0 for the other three combinations. The value is visible from that edge on.
- R3: While enabled and past the first edge, SDA low with SCL high at a clock edge sets busy_o to 1, even without a preceding SDA fall.
- R4: A START sets busy_o to 1. A START is SDA going from 1 to 0 between two consecutive edges while SCL is 1 at both edges.
- R5: A STOP clears busy_o to 0 and sets free_o to 1. A STOP is SDA going from 0 to 1 between two consecutive edges while SCL is 1 at both edges.
- R6: No START or STOP is recognised on the first enabled edge, whatever the line levels were before it.
- R7: free_o stays 1 until a clock edge with free_clr_i high or a reset. START, level-busy and disabling do not clear it.
- R8: When a STOP and free_clr_i come at the same edge, free_o is 1 afterwards.
- R9: evt_o is 1 for exactly the cycle after an edge at which busy_o rose from 0 to 1 or a STOP was detected, and 0 otherwise.
- R10: While en_i is low, busy_o is 0 after each edge and no START or STOP is detected.
- R11: SDA transitions while SCL is low change neither busy_o nor free_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Tracker enable |
| sda_i | input | 1 | Synchronized SDA level |
| scl_i | input | 1 | Synchronized SCL level |
| free_clr_i | input | 1 | Write-one-to-clear for the bus-free flag |
| busy_o | output | 1 | Bus busy flag |
| free_o | output | 1 | Sticky bus-free flag (set by STOP) |
| evt_o | output | 1 | One-cycle pulse when busy rises or a STOP is seen |

## Verification
The bench seeds all four line combinations at enable. A design that seeds with the wrong polarity, or that decodes SDA and SCL swapped, would report the wrong busy value. It enables the block across an SDA rise with SCL high, which catches a design that reports a false STOP from samples taken before enable and so sets the bus-free flag. It raises SCL while SDA is already low, which catches a design that only reacts to a SDA fall and misses busy. It toggles SDA with SCL low, which catches a design that ignores SCL and so sees START or STOP. It also clears the bus-free flag in the same cycle as a STOP, which catches a design that gives priority to the clear and loses the event.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  typedef struct packed {
    logic sda;
    logic scl;
  } line_t;

  // Data held low during clock high: ack level or a transfer in flight
  function automatic logic held_low(line_t l);
    return !l.sda && l.scl;
  endfunction
endpackage

// File: rtl/bt_edge_detect.sv
module bt_edge_detect
  import i2c_bt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  line_t line_i,
  output logic  first_o,
  output logic  start_o,
  output logic  stop_o,
  output logic  level_o
);
  line_t prev_q;
  logic  armed_q;
  logic  valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '{sda: 1'b1, scl: 1'b1};
      armed_q <= 1'b0;
    end else begin
      prev_q  <= line_i;
      armed_q <= en_i;
    end
  end

  assign first_o = en_i && !armed_q;
  assign valid   = en_i && armed_q;
  assign start_o = valid && prev_q.scl && line_i.scl && prev_q.sda && !line_i.sda;
  assign stop_o  = valid && prev_q.scl && line_i.scl && !prev_q.sda && line_i.sda;
  assign level_o = valid && held_low(line_i);

  AST_START_IMPLIES_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> level_o); // R4
endmodule

// File: rtl/bt_busy_flag.sv
module bt_busy_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic first_i,
  input  logic seed_i,
  input  logic level_i,
  input  logic stop_i,
  output logic busy_o,
  output logic rise_o
);
  logic busy_q, busy_d;

  always_comb begin
    if (!en_i)        busy_d = 1'b0;
    else if (first_i) busy_d = seed_i;
    else if (stop_i)  busy_d = 1'b0;
    else if (level_i) busy_d = 1'b1;
    else              busy_d = busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  assign busy_o = busy_q;
  assign rise_o = busy_d && !busy_q;

  AST_SEED_FOLLOWS_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_i |=> busy_o == $past(seed_i)); // R2
  AST_LEVEL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i |=> busy_o); // R3
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_o); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o); // R10
endmodule

// File: rtl/bt_free_flag.sv
module bt_free_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic free_o
);
  logic free_q;

  // set has priority so a STOP is never lost to a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    free_q <= 1'b0;
    else if (set_i) free_q <= 1'b1;
    else if (clr_i) free_q <= 1'b0;
  end

  assign free_o = free_q;

  AST_FREE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o && !clr_i |=> free_o); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> free_o); // R8
endmodule

// File: rtl/i2c_busy_tracker.sv
module i2c_busy_tracker
  import i2c_bt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sda_i,
  input  logic scl_i,
  input  logic free_clr_i,
  output logic busy_o,
  output logic free_o,
  output logic evt_o
);
  line_t line;
  logic  first, start, stop, level, rise;
  logic  evt_q;

  assign line = '{sda: sda_i, scl: scl_i};

  bt_edge_detect u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .line_i  (line),
    .first_o (first),
    .start_o (start),
    .stop_o  (stop),
    .level_o (level)
  );

  bt_busy_flag u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .first_i (first),
    .seed_i  (held_low(line)),
    .level_i (level),
    .stop_i  (stop),
    .busy_o  (busy_o),
    .rise_o  (rise)
  );

  bt_free_flag u_free (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stop),
    .clr_i  (free_clr_i),
    .free_o (free_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= rise || stop;
  end

  assign evt_o = evt_q;

  AST_EVT_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> busy_o || free_o); // R9
  AST_NO_STOP_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !stop && !start); // R10
endmodule

// File: tb/sim_i2c_busy_tracker.sv
module sim_i2c_busy_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, sda = 1'b1, scl = 1'b1, clr = 1'b0;
  logic busy, free, evt;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  i2c_busy_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sda_i(sda), .scl_i(scl),
    .free_clr_i(clr), .busy_o(busy), .free_o(free), .evt_o(evt)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(logic e, logic d, logic c, logic k);
    @(negedge clk);
    en = e; sda = d; scl = c; clr = k;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; sda = 1'b1; scl = 1'b1; clr = 1'b0;
    #1;
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "free in reset", free, 1'b0);
    chk("R1", "evt in reset", evt, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_seed(logic d, logic c);
    logic exp;
    do_reset();
    exp = !d && c;
    drive(1'b1, d, c, 1'b0);
    tick();
    chk("R2", $sformatf("seed busy sda=%b scl=%b", d, c), busy, exp);
    chk("R9", "seed evt", evt, exp);
    tick();
    chk("R9", "seed evt drop", evt, 1'b0);
  endtask

  task automatic t_first_no_edge();
    do_reset();
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    tick();
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    tick();
    chk("R6", "no stop on first edge, free", free, 1'b0);
    chk("R6", "first edge busy", busy, 1'b0);
    chk("R6", "first edge evt", evt, 1'b0);
  endtask

  task automatic t_start_stop();
    do_reset();
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    tick();
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    tick();
    chk("R4", "start busy", busy, 1'b1);
    chk("R9", "start evt", evt, 1'b1);
    tick();
    chk("R9", "start evt one cycle", evt, 1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    tick();
    chk("R5", "stop busy", busy, 1'b0);
    chk("R5", "stop free", free, 1'b1);
    chk("R9", "stop evt", evt, 1'b1);
    tick();
    chk("R9", "stop evt one cycle", evt, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    tick();
    chk("R7", "start keeps free", free, 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    tick();
    chk("R7", "disable keeps free", free, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    tick();
    chk("R7", "w1c clears free", free, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    tick();
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    tick();
    chk("R8", "stop beats clear", free, 1'b1);
    chk("R5", "stop with clear busy", busy, 1'b0);
  endtask

  task automatic t_scl_low();
    do_reset();
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    tick();
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    tick();
    chk("R11", "sda fall scl low busy", busy, 1'b0);
    drive(1'b1, 1'b1, 1'b0, 1'b0);
    tick();
    chk("R11", "sda rise scl low free", free, 1'b0);
    chk("R11", "sda rise scl low busy", busy, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    tick();
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    tick();
    chk("R3", "level sets busy", busy, 1'b1);
    chk("R9", "level evt", evt, 1'b1);
  endtask

  task automatic t_disable();
    do_reset();
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    tick();
    chk("R2", "seed busy", busy, 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    tick();
    chk("R10", "disabled busy", busy, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b0);
    tick();
    chk("R10", "no stop when disabled", free, 1'b0);
    chk("R10", "no evt when disabled", evt, 1'b0);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_seed(1'b0, 1'b0);
    t_seed(1'b1, 1'b0);
    t_seed(1'b0, 1'b1);
    t_seed(1'b1, 1'b1);
    t_first_no_edge();
    t_start_stop();
    t_scl_low();
    t_disable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule